// File: doc/BRIEF.md
# Two-Operand Bus ALU with Zero and Sign Detection

This block is the arithmetic and logic unit of a simple 32-bit teaching-style datapath. Two operand buses, called S1 and S2, feed it together with a 4-bit operation code. It places the outcome on a result bus and reports whether that outcome is zero and whether it is negative, so that a sequencing control unit can branch on either indication.

It offers the following functions:

- wrapping addition;
- subtraction in both operand orders;
- bitwise AND, OR and XOR;
- logical left and right shifts, and an arithmetic right shift;
- two pass-through modes, each of which copies one operand unchanged.

Every operation is evaluated by combinational logic in a single cycle. The result and both flags are captured in output registers, so values presented at one rising clock edge appear on the outputs right after that edge.

Top module: `alu_core`

## Requirements
- R1: Result and flags are registered. Inputs sampled at a rising edge are reflected on the outputs immediately after that edge. A synchronous active-high reset sets the result to 0, the zero flag to 1 and the negative flag to 0.
- R2: Code 0 gives S1+S2 and code 1 gives S1-S2. Both wrap modulo 2^32, and overflow is not reported.
- R3: Code 2 gives the reversed difference S2-S1, which also wraps modulo 2^32.
- R4: Code 3 gives S1 AND S2, code 4 gives S1 OR S2, and code 5 gives S1 XOR S2.
- R5: Code 6 shifts S1 left by the amount in S2[4:0] and fills with zeros. Bits S2[31:5] have no effect on any shift.
- R6: Code 7 shifts S1 right with zero fill. Code 8 shifts S1 right and fills with copies of S1[31]. Both use S2[4:0] as the amount.
- R7: Code 9 passes S1 unchanged, and code 10 passes S2 unchanged.
- R8: Codes 11 through 15 give a result of 0.
- R9: The zero flag is 1 exactly when all 32 result bits are 0.
- R10: The negative flag equals bit 31 of the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code |
| s1_i | input | 32 | First operand bus |
| s2_i | input | 32 | Second operand bus |
| res_o | output | 32 | Registered result bus |
| zero_o | output | 1 | Registered flag: result is zero |
| neg_o | output | 1 | Registered flag: result is negative |

## Verification
The assertions take for granted that the operation code and both operands hold known, settled values at every rising edge outside reset. The past-value checks on pass-through, addition, reversed subtraction and unused codes depend on this. The bench meets the assumption by changing inputs only on the falling edge and by holding every bus at a defined value from time zero, including during reset. The shift cases deliberately drive ones into S2[31:5], which stays within the assumption while exercising the masking of the shift amount.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned OP_W   = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_RSUB  = 4'd2,
    OP_AND   = 4'd3,
    OP_OR    = 4'd4,
    OP_XOR   = 4'd5,
    OP_SLL   = 4'd6,
    OP_SRL   = 4'd7,
    OP_SRA   = 4'd8,
    OP_PASSA = 4'd9,
    OP_PASSB = 4'd10
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'd0,
    SH_RLOG  = 2'd1,
    SH_RARI  = 2'd2
  } shift_kind_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned W = 32
) (
  input  logic         subtract,
  input  logic         swap,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum
);

  logic [W-1:0] lhs;
  logic [W-1:0] rhs;
  logic [W-1:0] rhs_eff;

  // A single adder serves add, subtract and reversed subtract.
  always_comb begin
    lhs     = swap ? b : a;
    rhs     = swap ? a : b;
    rhs_eff = subtract ? ~rhs : rhs;
    sum     = lhs + rhs_eff + {{(W-1){1'b0}}, subtract};
  end

endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int unsigned W = 32
) (
  input  logic [1:0]   sel,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);

  always_comb begin
    unique case (sel)
      2'd0:    y = a & b;
      2'd1:    y = a | b;
      2'd2:    y = a ^ b;
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
  import alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  shift_kind_e          kind,
  input  logic [W-1:0]         a,
  input  logic [$clog2(W)-1:0] amt,
  output logic [W-1:0]         y
);

  localparam int unsigned STAGES = $clog2(W);

  logic         fill;
  logic [W-1:0] lstg [0:STAGES];
  logic [W-1:0] rstg [0:STAGES];

  assign fill    = (kind == SH_RARI) ? a[W-1] : 1'b0;
  assign lstg[0] = a;
  assign rstg[0] = a;

  // Logarithmic barrel: stage i moves by 2**i when amount bit i is set.
  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    localparam int unsigned SH = 1 << i;
    assign lstg[i+1] = amt[i] ? {lstg[i][W-1-SH:0], {SH{1'b0}}} : lstg[i];
    assign rstg[i+1] = amt[i] ? {{SH{fill}}, rstg[i][W-1:SH]}   : rstg[i];
  end

  assign y = (kind == SH_LEFT) ? lstg[STAGES] : rstg[STAGES];

endmodule

// File: rtl/alu_flags.sv
module alu_flags #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] value,
  output logic         is_zero,
  output logic         is_neg
);

  assign is_zero = ~|value;
  assign is_neg  = value[W-1];

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    s1_i,
  input  logic [W-1:0]    s2_i,
  output logic [W-1:0]    res_o,
  output logic            zero_o,
  output logic            neg_o
);

  localparam int unsigned AMT_W = $clog2(W);

  logic        as_sub;
  logic        as_swap;
  logic [W-1:0] arith_y;
  logic [1:0]   logic_sel;
  logic [W-1:0] logic_y;
  shift_kind_e  sh_kind;
  logic [W-1:0] shift_y;
  logic [W-1:0] next_res;
  logic         next_zero;
  logic         next_neg;

  // Operation decode: steer the shared sub-units.
  always_comb begin
    as_sub    = (op_i == OP_SUB) || (op_i == OP_RSUB);
    as_swap   = (op_i == OP_RSUB);
    logic_sel = (op_i == OP_AND) ? 2'd0 :
                (op_i == OP_OR)  ? 2'd1 : 2'd2;
    sh_kind   = (op_i == OP_SLL) ? SH_LEFT :
                (op_i == OP_SRL) ? SH_RLOG : SH_RARI;
  end

  alu_addsub #(.W(W)) u_addsub (
    .subtract (as_sub),
    .swap     (as_swap),
    .a        (s1_i),
    .b        (s2_i),
    .sum      (arith_y)
  );

  alu_logic #(.W(W)) u_logic (
    .sel (logic_sel),
    .a   (s1_i),
    .b   (s2_i),
    .y   (logic_y)
  );

  alu_shifter #(.W(W)) u_shift (
    .kind (sh_kind),
    .a    (s1_i),
    .amt  (s2_i[AMT_W-1:0]),
    .y    (shift_y)
  );

  // Result bus selection; unlisted codes drive zero.
  always_comb begin
    case (op_i)
      OP_ADD, OP_SUB, OP_RSUB: next_res = arith_y;
      OP_AND, OP_OR, OP_XOR:   next_res = logic_y;
      OP_SLL, OP_SRL, OP_SRA:  next_res = shift_y;
      OP_PASSA:                next_res = s1_i;
      OP_PASSB:                next_res = s2_i;
      default:                 next_res = '0;
    endcase
  end

  alu_flags #(.W(W)) u_flags (
    .value   (next_res),
    .is_zero (next_zero),
    .is_neg  (next_neg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o  <= '0;
      zero_o <= 1'b1;
      neg_o  <= 1'b0;
    end else begin
      res_o  <= next_res;
      zero_o <= next_zero;
      neg_o  <= next_neg;
    end
  end

  AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (rst)
    zero_o == (res_o == '0));                                            // R9
  AST_NEG_MATCH: assert property (@(posedge clk) disable iff (rst)
    neg_o == res_o[W-1]);                                                // R10
  AST_ADD_WRAP: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_ADD) |=> (res_o - $past(s2_i) == $past(s1_i)));          // R2
  AST_RSUB_ORDER: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_RSUB) |=> (res_o + $past(s1_i) == $past(s2_i)));         // R3
  AST_PASS_S1: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_PASSA) |=> (res_o == $past(s1_i)));                      // R7
  AST_PASS_S2: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_PASSB) |=> (res_o == $past(s2_i)));                      // R7
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (op_i > OP_PASSB) |=> (res_o == '0 && zero_o));                      // R8
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (res_o == '0 && zero_o && !neg_o));                          // R1

endmodule

// File: tb/alu_core_test.sv
module alu_core_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op  = 4'd0;
  logic [31:0] s1  = 32'd0;
  logic [31:0] s2  = 32'd0;
  logic [31:0] res;
  logic        zf;
  logic        nf;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  alu_core uut (
    .clk    (clk),
    .rst    (rst),
    .op_i   (op),
    .s1_i   (s1),
    .s2_i   (s2),
    .res_o  (res),
    .zero_o (zf),
    .neg_o  (nf)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive on the falling edge; the registered output is valid at the next falling edge.
  task automatic run(input string req, input logic [3:0] o,
                     input logic [31:0] a, input logic [31:0] b,
                     input logic [31:0] exp);
    @(negedge clk);
    op = o; s1 = a; s2 = b;
    @(negedge clk);
    check(req, res, exp);
    check("R9 zero flag", {31'd0, zf}, {31'd0, exp == 32'd0});
    check("R10 neg flag", {31'd0, nf}, {31'd0, exp[31]});
  endtask

  task automatic t_reset();
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R1 reset result", res, 32'd0);
    check("R1 reset zero", {31'd0, zf}, 32'd1);
    check("R1 reset neg", {31'd0, nf}, 32'd0);
    rst = 1'b0;
  endtask

  task automatic t_arith();
    run("R2 add", 4'd0, 32'd1234, 32'd4321, 32'd5555);
    run("R2 add wrap", 4'd0, 32'hFFFF_FFFF, 32'd1, 32'd0);
    run("R2 sub", 4'd1, 32'd10, 32'd3, 32'd7);
    run("R2 sub negative", 4'd1, 32'd3, 32'd10, 32'hFFFF_FFF9);
    run("R3 rsub", 4'd2, 32'd3, 32'd10, 32'd7);
    run("R3 rsub wrap", 4'd2, 32'd1, 32'h8000_0000, 32'h7FFF_FFFF);
  endtask

  task automatic t_logic();
    run("R4 and", 4'd3, 32'hF0F0_1234, 32'hFF00_FF0F, 32'hF000_1204);
    run("R4 or",  4'd4, 32'hF0F0_1234, 32'h0F00_0001, 32'hFFF0_1235);
    run("R4 xor", 4'd5, 32'hAAAA_5555, 32'hAAAA_5555, 32'd0);
  endtask

  task automatic t_shift();
    run("R5 sll", 4'd6, 32'h0000_0003, 32'd4, 32'h0000_0030);
    run("R5 sll upper amount bits ignored", 4'd6, 32'h0000_0001, 32'hFFFF_FFE0 | 32'd31, 32'h8000_0000);
    run("R5 sll amount 32 masks to 0", 4'd6, 32'h1234_5678, 32'd32, 32'h1234_5678);
    run("R6 srl", 4'd7, 32'h8000_0000, 32'd4, 32'h0800_0000);
    run("R6 sra negative", 4'd8, 32'h8000_0000, 32'd4, 32'hF800_0000);
    run("R6 sra positive", 4'd8, 32'h4000_0000, 32'hABCD_0021, 32'h2000_0000);
    run("R6 sra by 31", 4'd8, 32'h8000_0001, 32'd31, 32'hFFFF_FFFF);
  endtask

  task automatic t_pass();
    run("R7 pass S1", 4'd9,  32'hDEAD_BEEF, 32'h0000_1111, 32'hDEAD_BEEF);
    run("R7 pass S2", 4'd10, 32'hDEAD_BEEF, 32'h0000_1111, 32'h0000_1111);
  endtask

  task automatic t_unused();
    for (int c = 11; c < 16; c++)
      run("R8 unused code", c[3:0], 32'hFFFF_FFFF, 32'h8000_0001, 32'd0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_arith();
    t_logic();
    t_shift();
    t_pass();
    t_unused();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule